// File: doc/BRIEF.md
# Pin-Strapped Two-Wire Bus Slave Front End

This block is the bus-facing half of a small register-bank peripheral on a two-wire serial bus (I2C). It oversamples the SCL and SDA lines with the system clock and recognises start and stop conditions. It collects the first byte of each transaction and claims it only when the top nibble is the fixed type code `0101` and the bottom nibble equals four strap inputs. The address byte carries no direction bit. After the address it hands each received byte to a command engine with a one-cycle strobe, tagged as either the instruction byte or a data byte.

The command engine steers the rest of the transaction. If it raises the read select by the end of the instruction byte's acknowledge, the slave transmits bytes taken from the engine's read-data input and keeps sending as long as the master acknowledges. The engine can also refuse a data byte, for example when the target storage is locked, by holding the refuse input when that byte completes. A busy input makes the slave ignore its own address, so that a master can poll for the end of a long internal write cycle. The slave drives SDA only through an open-drain pull-low enable. A stop that ends a claimed transaction produces a one-cycle done strobe, which is the engine's cue to commit a write.

Top module: `i2c_strap_slave`

## Requirements
- R1: A fall of SDA while SCL is high (start) begins reception of an address byte from bit 0. A rise of SDA while SCL is high (stop) returns the slave to idle. `xfer_done_o` pulses for one cycle at a stop only if the transaction's address was acknowledged.
- R2: An address byte, received MSB first, is claimed only when bits [7:4] are `0101` and bits [3:0] equal `strap_i[3:0]`.
- R3: The slave acknowledges by holding `sda_oe_o` high across the ninth SCL clock after a claimed address and after each accepted written byte. Outside of acknowledges and transmitted zero bits, `sda_oe_o` is low, and it is low after reset.
- R4: Each received byte after the address appears on `byte_o` with a one-cycle `byte_vld_o` pulse. `byte_is_data_o` is 0 for the first byte after the address (instruction) and 1 for every later byte. The address byte itself is never presented.
- R5: If `rd_sel_i` is high at the end of the instruction acknowledge, the slave sends `rd_data_i` MSB first and pulses `rd_take_o` as it loads each byte. A master acknowledge loads and sends the next byte. A master not-acknowledge makes the slave release SDA and stay silent until the next start or stop.
- R6: While `busy_i` is high when the eighth address bit is sampled, the slave does not acknowledge, delivers no bytes, and produces no `xfer_done_o` for that transaction.
- R7: If `refuse_i` is high when a data byte completes, that byte is still presented but not acknowledged, and later bytes are ignored until a start or stop. The instruction byte is never refused.
- R8: A start in the middle of a transaction discards the partial byte and restarts with address reception. The following byte is again tagged as instruction.
- R9: After an address that does not match, the slave ignores all bytes until the next start, neither acknowledging nor presenting them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 4 | Strapped low nibble of the slave address |
| busy_i | input | 1 | Internal write cycle in progress; address is ignored |
| refuse_i | input | 1 | Do not acknowledge the data byte completing now |
| rd_sel_i | input | 1 | Instruction selects a read; slave transmits next |
| rd_data_i | input | 8 | Byte to transmit when loaded |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| byte_o | output | 8 | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| byte_is_data_o | output | 1 | 0 = instruction byte, 1 = data byte |
| rd_take_o | output | 1 | One-cycle strobe when `rd_data_i` is loaded |
| xfer_done_o | output | 1 | One-cycle strobe at the stop ending a claimed transaction |

## Verification
Completing the last bit of a byte and the engine's decision on that byte fall in the same system-clock cycle. The eighth address bit is judged against `busy_i`, and the last bit of a data byte against `refuse_i`. The bench sets these inputs before the SCL edge that completes the byte, not after it. It then judges the outcome at the port, from the ninth-clock level on SDA and from whether the byte strobe and the done strobe fire. A repeated start placed in the middle of a byte checks that the start overrides the bit shifter on the cycle it is detected.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_TXE,
    ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_INSTR,
    BK_DATA
  } bk_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], din[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl[g]  = chain_q[STAGES-1];
    assign rise[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  // SDA edges count as bus conditions only while SCL stays high
  always_comb begin
    ev_start = sda_fall & scl_lvl & ~scl_rise;
    ev_stop  = sda_rise & scl_lvl & ~scl_rise;
    ev_rise  = scl_rise;
    ev_fall  = scl_fall;
  end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int STRAP_W = 4,
  parameter int TW      = DW - STRAP_W,
  parameter logic [TW-1:0] TYPE_ID = TW'(5)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               ev_rise,
  input  logic               ev_fall,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               refuse_i,
  input  logic               rd_sel_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               sda_oe,
  output logic [DW-1:0]      byte_o,
  output logic               byte_vld,
  output logic               byte_tag,
  output logic               rd_take,
  output logic               xfer_done
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  st_e              st_q, st_d;
  bk_e              kind_q, kind_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DW-2:0]    sh_q, sh_d;
  logic [DW-1:0]    tx_q, tx_d;
  logic             sel_q, sel_d;
  logic             mack_q, mack_d;
  logic             oe_q, oe_d;
  logic [DW-1:0]    byte_q, byte_d;
  logic             vld_q, vld_d;
  logic             tag_q, tag_d;
  logic             take_q, take_d;
  logic             done_q, done_d;
  logic [DW-1:0]    full;
  logic             hit;

  assign full = {sh_q, sda_s};
  assign hit  = (full[DW-1:STRAP_W] == TYPE_ID) && (full[STRAP_W-1:0] == strap_i);

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    sel_d  = sel_q;
    mack_d = mack_q;
    byte_d = byte_q;
    tag_d  = tag_q;
    vld_d  = 1'b0;
    take_d = 1'b0;
    done_d = 1'b0;
    if (ev_start) begin
      st_d   = ST_RX;
      kind_d = BK_ADDR;
      cnt_d  = '0;
      sel_d  = 1'b0;
    end else if (ev_stop) begin
      st_d   = ST_IDLE;
      done_d = sel_q;
      sel_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (ev_rise) begin
            sh_d  = full[DW-2:0];
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              if (kind_q == BK_ADDR) begin
                if (hit && !busy_i) begin
                  st_d  = ST_ACKW;
                  sel_d = 1'b1;
                end else begin
                  st_d = ST_IDLE;
                end
              end else begin
                vld_d  = 1'b1;
                byte_d = full;
                tag_d  = (kind_q == BK_DATA);
                st_d   = (kind_q == BK_DATA && refuse_i) ? ST_IDLE : ST_ACKW;
              end
            end
          end
        end
        ST_ACKW: begin
          if (ev_fall) st_d = ST_ACK;
        end
        ST_ACK: begin
          if (ev_fall) begin
            cnt_d = '0;
            if (kind_q == BK_ADDR) begin
              kind_d = BK_INSTR;
              st_d   = ST_RX;
            end else if (kind_q == BK_INSTR && rd_sel_i) begin
              st_d   = ST_TX;
              tx_d   = rd_data_i;
              take_d = 1'b1;
            end else begin
              kind_d = BK_DATA;
              st_d   = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              st_d  = ST_TXE;
            end
          end else if (ev_fall) begin
            tx_d = {tx_q[DW-2:0], 1'b0};
          end
        end
        ST_TXE: begin
          if (ev_fall) begin
            st_d   = ST_MACK;
            mack_d = 1'b0;
          end
        end
        ST_MACK: begin
          if (ev_rise) begin
            mack_d = ~sda_s;
          end else if (ev_fall) begin
            if (mack_q) begin
              st_d   = ST_TX;
              tx_d   = rd_data_i;
              take_d = 1'b1;
              cnt_d  = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
    oe_d = (st_d == ST_ACK) ||
           (((st_d == ST_TX) || (st_d == ST_TXE)) && !tx_d[DW-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= BK_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      sel_q  <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      tag_q  <= 1'b0;
      take_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      sel_q  <= sel_d;
      mack_q <= mack_d;
      oe_q   <= oe_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      take_q <= take_d;
      done_q <= done_d;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_o    = byte_q;
  assign byte_vld  = vld_q;
  assign byte_tag  = tag_q;
  assign rd_take   = take_q;
  assign xfer_done = done_q;

  // a start always restarts address reception from the first bit (R1, R8)
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st_q == ST_RX && kind_q == BK_ADDR && cnt_q == '0));

  // the line is only ever pulled low starting just after an SCL fall
  assert_drive_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(ev_fall));

  // busy at the last address bit leaves the slave unselected and idle
  assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX && kind_q == BK_ADDR && cnt_q == LAST && ev_rise && busy_i &&
     !ev_start && !ev_stop) |=> (st_q == ST_IDLE && !sel_q && !oe_q));

  // a refused data byte is not acknowledged
  assert_refuse_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX && kind_q == BK_DATA && cnt_q == LAST && ev_rise && refuse_i &&
     !ev_start && !ev_stop) |=> (st_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
  parameter int DW      = 8,
  parameter int STRAP_W = 4,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               refuse_i,
  input  logic               rd_sel_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               sda_oe_o,
  output logic [DW-1:0]      byte_o,
  output logic               byte_vld_o,
  output logic               byte_is_data_o,
  output logic               rd_take_o,
  output logic               xfer_done_o
);
  localparam int TW = DW - STRAP_W;

  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic [1:0] lvl, rise, fall;
  logic       ev_start, ev_stop, ev_rise, ev_fall;

  // line 1 = SCL, line 0 = SDA
  i2cs_sync #(.N(2), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .din  ({scl_i, sda_i}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  i2cs_cond u_cond (
    .scl_lvl (lvl[1]),
    .scl_rise(rise[1]),
    .scl_fall(fall[1]),
    .sda_rise(rise[0]),
    .sda_fall(fall[0]),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  i2cs_fsm #(.DW(DW), .STRAP_W(STRAP_W), .TW(TW), .TYPE_ID(TW'(5))) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .sda_s    (lvl[0]),
    .strap_i  (strap_i),
    .busy_i   (busy_i),
    .refuse_i (refuse_i),
    .rd_sel_i (rd_sel_i),
    .rd_data_i(rd_data_i),
    .sda_oe   (sda_oe_o),
    .byte_o   (byte_o),
    .byte_vld (byte_vld_o),
    .byte_tag (byte_is_data_o),
    .rd_take  (rd_take_o),
    .xfer_done(xfer_done_o)
  );

  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    byte_vld_o |=> !byte_vld_o);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer_done_o |=> !xfer_done_o);
endmodule

// File: tb/i2c_strap_slave_tb.sv
`timescale 1ns/1ps
module i2c_strap_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [3:0] strap = 4'h0;
  logic       busy = 1'b0;
  logic       refuse = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_seed = 8'h00;
  logic [7:0] rd_data;
  logic       sda_oe, byte_vld, byte_is_data, rd_take, xfer_done;
  logic [7:0] byte_out;
  wire        sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0;
  int nvld = 0, ndone = 0, ntake = 0;
  logic [7:0] last_b = 8'h00;
  logic       last_tag = 1'b0;

  always #2.5 clk = ~clk;

  assign rd_data = rd_seed + 8'(ntake * 17);

  i2c_strap_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .busy_i(busy), .refuse_i(refuse), .rd_sel_i(rd_sel),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe), .byte_o(byte_out),
    .byte_vld_o(byte_vld), .byte_is_data_o(byte_is_data),
    .rd_take_o(rd_take), .xfer_done_o(xfer_done)
  );

  always @(negedge clk) begin
    if (byte_vld) begin
      nvld++;
      last_b   <= byte_out;
      last_tag <= byte_is_data;
    end
    if (xfer_done) ndone++;
    if (rd_take)   ntake++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wc(4); m_sda = b; wc(4); m_scl = 1'b1; wc(8); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wc(4); m_sda = 1'b1; wc(4); m_scl = 1'b1; wc(4); b = sda_line; wc(4); m_scl = 1'b0;
  endtask

  task automatic m_start();
    wc(4); m_sda = 1'b1; wc(4); m_scl = 1'b1; wc(6); m_sda = 1'b0; wc(6); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    wc(4); m_sda = 1'b0; wc(4); m_scl = 1'b1; wc(6); m_sda = 1'b1; wc(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~mack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         v0, d0;

    wc(5); rst_n = 1'b1; wc(10);
    // R3: idle after reset
    chk("R3 reset oe", int'(sda_oe), 0);
    chk("R4 reset vld", int'(byte_vld), 0);

    // R2 exhaustive address sweep with strap = A
    strap = 4'hA;
    d0 = ndone; v0 = nvld;
    for (int a = 0; a < 256; a++) begin
      m_start();
      wr_byte(8'(a), ack);
      chk($sformatf("R2 addr %02h", a), int'(ack), int'(a == 8'h5A));
      m_stop();
    end
    chk("R1 done count after sweep", ndone - d0, 1);
    chk("R4 address not presented", nvld - v0, 0);

    // R2 strap sweep
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      m_start(); wr_byte({4'b0101, 4'(s)}, ack); m_stop();
      chk($sformatf("R2 strap %0d match", s), int'(ack), 1);
      m_start(); wr_byte({4'b0101, 4'(s) ^ 4'h8}, ack); m_stop();
      chk($sformatf("R2 strap %0d miss", s), int'(ack), 0);
    end

    // R3 R4 write with instruction and two data bytes
    strap = 4'h3;
    d0 = ndone; v0 = nvld;
    m_start();
    wr_byte(8'h53, ack); chk("R3 addr ack", int'(ack), 1);
    wr_byte(8'h9A, ack); chk("R3 instr ack", int'(ack), 1);
    chk("R4 instr value", int'(last_b), 8'h9A);
    chk("R4 instr tag", int'(last_tag), 0);
    wr_byte(8'h5C, ack); chk("R3 data ack", int'(ack), 1);
    chk("R4 data value", int'(last_b), 8'h5C);
    chk("R4 data tag", int'(last_tag), 1);
    wr_byte(8'h33, ack); chk("R3 data2 ack", int'(ack), 1);
    chk("R4 data2 tag", int'(last_tag), 1);
    chk("R1 no done before stop", ndone - d0, 0);
    m_stop();
    chk("R4 three bytes", nvld - v0, 3);
    chk("R1 done at stop", ndone - d0, 1);
    chk("R3 released idle", int'(sda_oe), 0);

    // R5 read with master ack then nack
    rd_seed = 8'hC5 - 8'(ntake * 17);
    d0 = ndone;
    rd_sel = 1'b1;
    m_start();
    wr_byte(8'h53, ack);
    wr_byte(8'h90, ack); chk("R5 read instr ack", int'(ack), 1);
    rd_byte(1'b1, rb); chk("R5 first read byte", int'(rb), 8'hC5);
    rd_byte(1'b0, rb); chk("R5 second read byte", int'(rb), 8'hD6);
    rd_byte(1'b0, rb); chk("R5 silent after nack", int'(rb), 8'hFF);
    rd_sel = 1'b0;
    m_stop();
    chk("R1 done after read", ndone - d0, 1);

    // R6 busy ignores the address, then polling succeeds
    d0 = ndone; v0 = nvld;
    busy = 1'b1;
    m_start(); wr_byte(8'h53, ack); chk("R6 busy no ack", int'(ack), 0);
    wr_byte(8'h90, ack); chk("R6 busy byte ignored", int'(ack), 0);
    m_stop();
    chk("R6 busy no done", ndone - d0, 0);
    chk("R6 busy no byte", nvld - v0, 0);
    busy = 1'b0;
    m_start(); wr_byte(8'h53, ack); chk("R6 poll ack", int'(ack), 1); m_stop();

    // R7 refused data byte
    d0 = ndone;
    refuse = 1'b1;
    m_start();
    wr_byte(8'h53, ack);
    wr_byte(8'hC1, ack); chk("R7 instr not refused", int'(ack), 1);
    v0 = nvld;
    wr_byte(8'h77, ack); chk("R7 data nack", int'(ack), 0);
    chk("R7 refused byte shown", nvld - v0, 1);
    chk("R7 refused value", int'(last_b), 8'h77);
    wr_byte(8'h11, ack); chk("R7 later byte nack", int'(ack), 0);
    chk("R7 later byte hidden", nvld - v0, 1);
    m_stop();
    refuse = 1'b0;
    chk("R1 done after refused", ndone - d0, 1);

    // R9 mismatch ignores following bytes
    d0 = ndone; v0 = nvld;
    m_start();
    wr_byte(8'h54, ack); chk("R9 miss addr", int'(ack), 0);
    wr_byte(8'h53, ack); chk("R9 addr value as data ignored", int'(ack), 0);
    m_stop();
    chk("R9 nothing shown", nvld - v0, 0);
    chk("R9 no done", ndone - d0, 0);

    // R8 repeated start in the middle of a byte
    v0 = nvld;
    m_start();
    wr_byte(8'h53, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    m_start();
    wr_byte(8'h53, ack); chk("R8 addr after restart", int'(ack), 1);
    wr_byte(8'h42, ack); chk("R8 instr ack", int'(ack), 1);
    chk("R8 one byte shown", nvld - v0, 1);
    chk("R8 instr value", int'(last_b), 8'h42);
    chk("R8 instr tag", int'(last_tag), 0);
    m_stop();

    wc(20);
    finish_run();
  end
endmodule